// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches a bank of general-purpose input pins and turns each pin's activity into four event flags: pin low, pin high, falling edge and rising edge. Every pin first passes through a two-flop synchronizer. The two level flags follow the synchronized pin directly and are never stored. The two edge flags are set when the synchronized value differs from its previous sample, and they stay set until software clears them.

The flags are packed into 32-bit words, four bits per pin and eight pins per word. Pin N uses word N/8, bits 4*(N mod 8) to 4*(N mod 8)+3. Inside that nibble, bit 0 is low, bit 1 is high, bit 2 is fall and bit 3 is rise. There are three enable sets with the same packing: one for each of the two processors and one for dormant wake. Each processor's enable set masks the flags into that processor's pending status. The OR of a processor's pending bits drives its interrupt line. The wake enable set is applied the same way to drive a wake request.

Software talks to the block through a single-cycle write port and a combinational read port. The address is {region[2:0], word[1:0]}. Region 0 holds the event flags, where a write clears edge bits (write-one-to-clear). Regions 1 and 2 are the enables for processors 0 and 1. Region 3 is the wake enable. Regions 4 and 5 hold the masked status for processors 0 and 1.

Top module: `gpio_evt_top`

## Requirements
- R1: Nibble bit 0 reads 1 while the synchronized pin is 0, and bit 1 reads 1 while it is 1. Both bits follow the pin with no memory: they settle two clocks after the pin changes.
- R2: A 0-to-1 change of the synchronized pin sets nibble bit 3. The bit stays set after the pin returns to 0.
- R3: A 1-to-0 change of the synchronized pin sets nibble bit 2. The bit stays set after the pin returns to 1.
- R4: A write to region 0 clears exactly those edge bits (bits 2 and 3 of each nibble) whose written bit is 1. It has no effect on level bits or on nibbles written with 0.
- R5: Pin N occupies word N/8, bits 4*(N mod 8)+3 down to 4*(N mod 8). Word bits that belong to no pin (bits 31:24 of word 3 with 30 pins) read 0 in every region.
- R6: Region 4+p reads the event flags ANDed with processor p's enable set. The enables written for one processor do not change the other processor's status.
- R7: irqOut[p] is 1 exactly when any bit of processor p's masked status is 1.
- R8: wakeOut is 1 exactly when any event flag ANDed with the wake enable set is 1.
- R9: After reset all edge flags and all enables are 0, so irqOut and wakeOut are 0 and each nibble reads 0x1 while its pin is low.
- R10: When an edge is detected in the same cycle as a write that clears that edge bit, the new edge wins and the bit reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 30 | Asynchronous pin levels |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 5 | Write address {region, word} |
| wrData | input | 32 | Write data (enable value or clear mask) |
| rdAddr | input | 5 | Read address {region, word} |
| rdData | output | 32 | Combinational read data |
| irqOut | output | 2 | Per-processor interrupt requests |
| wakeOut | output | 1 | Dormant wake request |

## Verification
Single pins are pulsed high-then-low and low-then-high so that the live level bits can be told apart from the sticky edge bits in the same nibble. Pins near word boundaries (0, 8, 12, 20, 29) confirm the packing and show that the pad bits stay 0. Clear masks that touch only one edge bit of one nibble separate a selective clear from a whole-word clear. Enables chosen as a rise bit for one processor and a low-level bit for the other show that the two interrupt lines are independent. A rising edge timed to land in the same cycle as its own clear confirms that setting has priority.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int PIN_COUNT     = 30;
  localparam int PROC_COUNT    = 2;
  localparam int EVT_BITS      = 4;
  localparam int DATA_W        = 32;
  localparam int EN_SETS       = PROC_COUNT + 1;          // last set drives wake
  localparam int PINS_PER_WORD = DATA_W / EVT_BITS;
  localparam int WORD_COUNT    = (PIN_COUNT + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int WSEL_W        = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1;
  localparam int SET_W         = $clog2(EN_SETS);
  localparam int REGION_W      = $clog2(1 + EN_SETS + PROC_COUNT);
  localparam int ADDR_W        = REGION_W + WSEL_W;

  typedef enum logic [1:0] {RD_RAW, RD_ENABLE, RD_STATUS, RD_NONE} rdKind_e;

  typedef struct packed {
    logic              ackHit;
    logic              enHit;
    logic [SET_W-1:0]  enSet;
    logic [WSEL_W-1:0] wrWord;
    rdKind_e           rdKind;
    logic [SET_W-1:0]  rdSet;
    logic [WSEL_W-1:0] rdWord;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobe_t       strobe
);
  logic [REGION_W-1:0] wrRegion, rdRegion;
  logic [WSEL_W-1:0]   wrWord, rdWord;
  logic                wrWordOk, rdWordOk;

  assign {wrRegion, wrWord} = wrAddr;
  assign {rdRegion, rdWord} = rdAddr;
  assign wrWordOk = int'(wrWord) < WORD_COUNT;
  assign rdWordOk = int'(rdWord) < WORD_COUNT;

  // Region map: 0 event flags, 1..EN_SETS enable sets, then per-processor status
  always_comb begin
    strobe        = '0;
    strobe.rdKind = RD_NONE;
    strobe.wrWord = wrWord;
    strobe.rdWord = rdWord;
    if (wrEn && wrWordOk) begin
      if (wrRegion == '0) begin
        strobe.ackHit = 1'b1;
      end else if (int'(wrRegion) <= EN_SETS) begin
        strobe.enHit = 1'b1;
        strobe.enSet = SET_W'(int'(wrRegion) - 1);
      end
    end
    if (rdWordOk) begin
      if (rdRegion == '0) begin
        strobe.rdKind = RD_RAW;
      end else if (int'(rdRegion) <= EN_SETS) begin
        strobe.rdKind = RD_ENABLE;
        strobe.rdSet  = SET_W'(int'(rdRegion) - 1);
      end else if (int'(rdRegion) <= EN_SETS + PROC_COUNT) begin
        strobe.rdKind = RD_STATUS;
        strobe.rdSet  = SET_W'(int'(rdRegion) - 1 - EN_SETS);
      end
    end
  end
endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic [DATA_W-1:0]     wrData,
  input  ctrlStrobe_t           strobe,
  output logic [PROC_COUNT-1:0] irqOut,
  output logic                  wakeOut,
  output logic [DATA_W-1:0]     rdData
);
  localparam int FLAT_W = WORD_COUNT * DATA_W;
  localparam int USED_W = PIN_COUNT * EVT_BITS;

  logic [PIN_COUNT-1:0] syncA, pinSync, pinPrev;
  logic [PIN_COUNT-1:0] riseQ, fallQ, clrRise, clrFall;
  logic [PIN_COUNT-1:0][EVT_BITS-1:0] evt;
  logic [EN_SETS-1:0][PIN_COUNT-1:0][EVT_BITS-1:0] enQ, masked;
  logic [EN_SETS-1:0] anyHit;
  logic [FLAT_W-1:0] rawFlat;
  logic [EN_SETS-1:0][FLAT_W-1:0] enFlat, mskFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      pinSync <= '0;
      pinPrev <= '0;
    end else begin
      syncA   <= pinIn;
      pinSync <= syncA;
      pinPrev <= pinSync;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    localparam int WIDX = i / PINS_PER_WORD;
    localparam int BOFS = (i % PINS_PER_WORD) * EVT_BITS;
    logic wordHit, riseBit, fallBit;

    assign wordHit    = int'(strobe.wrWord) == WIDX;
    assign clrFall[i] = strobe.ackHit && wordHit && wrData[BOFS+2];
    assign clrRise[i] = strobe.ackHit && wordHit && wrData[BOFS+3];

    // a fresh edge has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseBit <= 1'b0;
        fallBit <= 1'b0;
      end else begin
        riseBit <= (pinSync[i] & ~pinPrev[i]) | (riseBit & ~clrRise[i]);
        fallBit <= (~pinSync[i] & pinPrev[i]) | (fallBit & ~clrFall[i]);
      end
    end
    assign riseQ[i] = riseBit;
    assign fallQ[i] = fallBit;
    assign evt[i]   = {riseBit, fallBit, pinSync[i], ~pinSync[i]};

    for (genvar s = 0; s < EN_SETS; s++) begin : g_set
      logic [EVT_BITS-1:0] enBits;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          enBits <= '0;
        else if (strobe.enHit && int'(strobe.enSet) == s && wordHit)
          enBits <= wrData[BOFS +: EVT_BITS];
      end
      assign enQ[s][i]    = enBits;
      assign masked[s][i] = evt[i] & enBits;
    end

    // R2
    rise_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (riseQ[i] && !clrRise[i]) |=> riseQ[i]);
    // R4
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(riseQ[i]) |-> $past(clrRise[i]));
    // R3
    fall_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(fallQ[i]) |-> $past(pinPrev[i] && !pinSync[i]));
  end

  for (genvar s = 0; s < EN_SETS; s++) begin : g_hit
    assign anyHit[s] = |masked[s];
    // R7
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      anyHit[s] |-> (|enQ[s]));
  end

  assign irqOut  = anyHit[PROC_COUNT-1:0];
  assign wakeOut = anyHit[PROC_COUNT];

  always_comb begin
    rawFlat = '0;
    rawFlat[USED_W-1:0] = evt;
    for (int s = 0; s < EN_SETS; s++) begin
      enFlat[s]  = '0;
      mskFlat[s] = '0;
      enFlat[s][USED_W-1:0]  = enQ[s];
      mskFlat[s][USED_W-1:0] = masked[s];
    end
  end

  always_comb begin
    unique case (strobe.rdKind)
      RD_RAW:    rdData = rawFlat[int'(strobe.rdWord)*DATA_W +: DATA_W];
      RD_ENABLE: rdData = enFlat[strobe.rdSet][int'(strobe.rdWord)*DATA_W +: DATA_W];
      RD_STATUS: rdData = mskFlat[strobe.rdSet][int'(strobe.rdWord)*DATA_W +: DATA_W];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic [PROC_COUNT-1:0] irqOut,
  output logic                  wakeOut
);
  ctrlStrobe_t strobe;

  gpio_evt_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  gpio_evt_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .wrData  (wrData),
    .strobe  (strobe),
    .irqOut  (irqOut),
    .wakeOut (wakeOut),
    .rdData  (rdData)
  );
endmodule

// File: tb/sim_gpio_evt_top.sv
module sim_gpio_evt_top;
  import gpio_evt_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [PIN_COUNT-1:0] pins;
  logic wrEn;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [DATA_W-1:0] wrData, rdData;
  logic [PROC_COUNT-1:0] irq;
  logic wake;
  int checks = 0;
  int fails = 0;

  gpio_evt_top u0 (.clk(clk), .rstN(rstN), .pinIn(pins), .wrEn(wrEn), .wrAddr(wrAddr),
                   .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irq), .wakeOut(wake));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(int region, int word);
    return ADDR_W'(region * (1 << WSEL_W) + word);
  endfunction

  task automatic wr(int region, int word, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = mkAddr(region, word); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(int region, int word, output logic [31:0] d);
    @(negedge clk); rdAddr = mkAddr(region, word); #1; d = rdData;
  endtask

  task automatic nib(int pin, output logic [3:0] n);
    logic [31:0] w;
    rd(0, pin / PINS_PER_WORD, w);
    n = w[(pin % PINS_PER_WORD) * EVT_BITS +: EVT_BITS];
  endtask

  task automatic setPin(int n, logic v);
    @(negedge clk); pins[n] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] w;
    for (int k = 0; k < 3; k++) begin rd(0, k, w); chk("R9 flags word", w, 32'h1111_1111); end
    rd(0, 3, w); chk("R9/R5 flags last word", w, 32'h0011_1111);
    rd(1, 0, w); chk("R9 enable p0", w, 0);
    rd(3, 2, w); chk("R9 wake enable", w, 0);
    chk("R9 irq", {30'd0, irq}, 0);
    chk("R9 wake", {31'd0, wake}, 0);
  endtask

  task automatic tLevel();
    logic [3:0] n;
    setPin(5, 1'b1); nib(5, n); chk("R1 high level + rise", {28'd0, n}, 32'hA);
    setPin(5, 1'b0); nib(5, n); chk("R1 low level live", {28'd0, n}, 32'hD);
    wr(0, 0, 32'hFFFF_FFFF); nib(5, n); chk("R4 ack keeps level", {28'd0, n}, 32'h1);
  endtask

  task automatic tEdges();
    logic [3:0] n;
    setPin(12, 1'b1); setPin(12, 1'b0); nib(12, n);
    chk("R2/R3 both edges held", {28'd0, n}, 32'hD);
    wr(0, 1, 32'h0008_0000); nib(12, n); chk("R4 clear rise only", {28'd0, n}, 32'h5);
    nib(8, n); chk("R4 neighbour untouched", {28'd0, n}, 32'h1);
    wr(0, 1, 32'h0004_0000); nib(12, n); chk("R4 clear fall", {28'd0, n}, 32'h1);
  endtask

  task automatic tLastPin();
    logic [3:0] n;
    logic [31:0] w;
    setPin(29, 1'b1); nib(29, n); chk("R5 pin29 nibble", {28'd0, n}, 32'hA);
    rd(0, 3, w); chk("R5 pad bits zero", {24'd0, w[31:24]}, 0);
    wr(0, 3, 32'hFFFF_FFFF); nib(29, n); chk("R4 high level stays", {28'd0, n}, 32'h2);
    setPin(29, 1'b0); nib(29, n); chk("R3 fall on pin29", {28'd0, n}, 32'h5);
    wr(0, 3, 32'hFFFF_FFFF);
    wr(1, 3, 32'hFFFF_FFFF); rd(1, 3, w); chk("R5 enable pad bits", w, 32'h00FF_FFFF);
    wr(1, 3, 0);
  endtask

  task automatic tMask();
    logic [31:0] w;
    wr(1, 0, 32'h8); wr(2, 0, 32'h1);
    rd(4, 0, w); chk("R6 p0 status idle", w, 0);
    rd(5, 0, w); chk("R6 p1 status low", w, 32'h1);
    chk("R7 irq p1 only", {30'd0, irq}, 32'h2);
    setPin(0, 1'b1);
    rd(4, 0, w); chk("R6 p0 rise", w, 32'h8);
    rd(5, 0, w); chk("R6 p1 low gone", w, 0);
    chk("R7 irq p0 only", {30'd0, irq}, 32'h1);
    setPin(0, 1'b0);
    @(negedge clk); chk("R7 irq both", {30'd0, irq}, 32'h3);
    wr(0, 0, 32'hFFFF_FFFF);
    rd(4, 0, w); chk("R6 p0 cleared", w, 0);
    chk("R7 irq after ack", {30'd0, irq}, 32'h2);
    wr(1, 0, 0); wr(2, 0, 0);
    @(negedge clk); chk("R7 irq disabled", {30'd0, irq}, 0);
  endtask

  task automatic tWake();
    wr(3, 1, 32'h2);
    @(negedge clk); chk("R8 wake idle", {31'd0, wake}, 0);
    setPin(8, 1'b1); chk("R8 wake on high", {31'd0, wake}, 1);
    setPin(8, 1'b0); chk("R8 wake follows level", {31'd0, wake}, 0);
    wr(3, 1, 32'h8);
    @(negedge clk); chk("R8 wake on held rise", {31'd0, wake}, 1);
    wr(0, 1, 32'hFFFF_FFFF);
    @(negedge clk); chk("R8 wake after ack", {31'd0, wake}, 0);
    wr(3, 1, 0);
  endtask

  task automatic tRace();
    logic [3:0] n;
    @(negedge clk); pins[20] = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrAddr = mkAddr(0, 2); wrData = 32'hFFFF_FFFF;
    @(negedge clk); wrEn = 1'b0;
    nib(20, n); chk("R10 edge beats clear", {28'd0, n}, 32'hA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; pins = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tLevel();
    tEdges();
    tLastPin();
    tMask();
    tWake();
    tRace();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule